// File: doc/BRIEF.md
# Write-Once Flash Timing Clock Divider

This block holds one 8-bit control register and a programmable counter that divides the oscillator clock down to a timing tick of roughly 1 MHz. A non-volatile memory controller uses that tick to time its program and erase pulses. Software writes a 7-bit divisor once after reset. From then on the counter emits a single-cycle enable every (divisor + 1) oscillator cycles. A `div_valid_o` output tells the command logic that the tick can be trusted.

The register is locked after its first accepted write, and a read-only flag in the top bit shows that this write has happened. While a command is running, writes are dropped, so the timing base cannot change under an active operation. The only exception is the reset sequence, when the register stays writable even though the command-complete indication is still low. A dropped write does not use up the one-time write.

Top module: `flash_tick_divider`

## Requirements
- R1: After reset the register reads 0x00, `div_valid_o` is 0 and `tick_o` is 0.
- R2: With `addr_i` equal to offset 0, `rdata_o` is {loaded flag in bit 7, divisor in bits 6:0}. Any other offset reads 0x00.
- R3: The first accepted write to offset 0 stores `wdata_i[6:0]` as the divisor and sets the loaded flag. Bit 7 of the write data has no effect, and the flag reads 1 whatever value was written there.
- R4: Once the loaded flag is set, further writes leave the whole register unchanged until the next reset.
- R5: A write while `cmd_busy_i`=1 and `rst_seq_i`=0 is dropped. It does not set the loaded flag or store the divisor, and a later permitted write is still accepted.
- R6: A write while `cmd_busy_i`=1 and `rst_seq_i`=1 is accepted like an idle write.
- R7: Once loaded, `tick_o` is high for exactly one cycle in every (divisor + 1) cycles. The first pulse falls in cycle divisor+1 after the accepting clock edge, where cycle 1 is the one that starts at that edge. A divisor of 0 gives a tick in every cycle.
- R8: `tick_o` stays 0 while the loaded flag is 0.
- R9: `div_valid_o` equals the loaded flag and rises only after an accepted write.
- R10: Writes to any offset other than 0 have no effect on the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register offset |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| cmd_busy_i | input | 1 | A memory command is executing |
| rst_seq_i | input | 1 | The reset sequence is active |
| tick_o | output | 1 | Single-cycle timing enable |
| div_valid_o | output | 1 | Divisor has been configured |

## Verification
The bench goes after four kinds of fault.

- **Dropped busy write.** A write during a busy command is followed by a legal one. A design that let the dropped write use up the one-time slot would keep the register at 0x00 and never tick.
- **Busy write during the reset sequence.** A write with the busy input and the reset-sequence input both high must be accepted. A design that ignored the reset-sequence exception would stay unloaded.
- **Divisor extremes.** The divisors 0 and 127 are checked cycle by cycle, along with the placement of the first pulse. An off-by-one counter shows up as a tick one cycle early or late.
- **Lockout and data bit 7.** Repeated writes after loading, and writes with bit 7 both set and clear, show whether the lock holds and whether bit 7 ever leaks into the flag.

// File: rtl/flash_div_pkg.sv
package flash_div_pkg;
  localparam int unsigned DIV_W = 7;
  localparam int unsigned REG_W = DIV_W + 1;

  typedef logic [DIV_W-1:0] div_t;

  typedef struct packed {
    logic loaded;
    div_t div;
  } ctl_reg_t;
endpackage

// File: rtl/fdiv_write_gate.sv
module fdiv_write_gate (
  input  logic wr_en_i,
  input  logic addr_hit_i,
  input  logic cmd_busy_i,
  input  logic rst_seq_i,
  input  logic loaded_i,
  output logic accept_o
);
  logic permit;

  // busy blocks writes except while the reset sequence runs
  assign permit   = !cmd_busy_i || rst_seq_i;
  assign accept_o = wr_en_i && addr_hit_i && permit && !loaded_i;
endmodule

// File: rtl/fdiv_ctl_reg.sv
module fdiv_ctl_reg
  import flash_div_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  div_t     div_i,
  output ctl_reg_t reg_o
);
  ctl_reg_t reg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q <= '0;
    end else if (load_i) begin
      reg_q.loaded <= 1'b1;
      reg_q.div    <= div_i;
    end
  end

  assign reg_o = reg_q;
endmodule

// File: rtl/fdiv_tick_gen.sv
module fdiv_tick_gen
  import flash_div_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  input  div_t div_i,
  output logic tick_o
);
  div_t cnt_q;
  logic at_end;

  assign at_end = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i || !run_i || at_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + div_t'(1);
    end
  end

  assign tick_o = run_i && at_end;
endmodule

// File: rtl/flash_tick_divider.sv
module flash_tick_divider
  import flash_div_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned REG_OFFSET = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              cmd_busy_i,
  input  logic              rst_seq_i,
  output logic              tick_o,
  output logic              div_valid_o
);
  localparam logic [ADDR_W-1:0] RegAddr = ADDR_W'(REG_OFFSET);

  logic     addr_hit;
  logic     accept;
  ctl_reg_t ctl_q;
  logic     unused_wdata_msb;

  assign addr_hit         = (addr_i == RegAddr);
  assign unused_wdata_msb = wdata_i[REG_W-1];

  fdiv_write_gate gate_i (
    .wr_en_i    (wr_en_i),
    .addr_hit_i (addr_hit),
    .cmd_busy_i (cmd_busy_i),
    .rst_seq_i  (rst_seq_i),
    .loaded_i   (ctl_q.loaded),
    .accept_o   (accept)
  );

  fdiv_ctl_reg reg_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .div_i  (wdata_i[DIV_W-1:0]),
    .reg_o  (ctl_q)
  );

  fdiv_tick_gen tick_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (accept),
    .run_i     (ctl_q.loaded),
    .div_i     (ctl_q.div),
    .tick_o    (tick_o)
  );

  assign rdata_o     = addr_hit ? ctl_q : '0;
  assign div_valid_o = ctl_q.loaded;
endmodule

// File: rtl/flash_tick_divider_chk.sv
module flash_tick_divider_chk
  import flash_div_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned REG_OFFSET = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              cmd_busy_i,
  input logic              rst_seq_i,
  input logic              tick_o,
  input logic              div_valid_o,
  input div_t              div_q
);
  logic           hit;
  logic [DIV_W:0] gap_q;

  assign hit = (addr_i == ADDR_W'(REG_OFFSET));

  // cycles since the accepting edge or the last tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     gap_q <= 1;
    else if (!div_valid_o || tick_o) gap_q <= 1;
    else                             gap_q <= gap_q + 1'b1;
  end

  assert_no_tick_unloaded_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_valid_o |-> !tick_o);

  assert_valid_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_valid_o |=> div_valid_o);

  assert_div_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_valid_o |=> $stable(div_q));

  assert_busy_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit && cmd_busy_i && !rst_seq_i && !div_valid_o) |=> !div_valid_o);

  assert_seq_accept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit && cmd_busy_i && rst_seq_i && !div_valid_o) |=> div_valid_o);

  assert_tick_period_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (gap_q == {1'b0, div_q} + 1'b1));

  assert_valid_after_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_valid_o) |-> $past(wr_en_i && hit));
endmodule

bind flash_tick_divider flash_tick_divider_chk #(
  .ADDR_W     (ADDR_W),
  .REG_OFFSET (REG_OFFSET)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wr_en_i     (wr_en_i),
  .cmd_busy_i  (cmd_busy_i),
  .rst_seq_i   (rst_seq_i),
  .tick_o      (tick_o),
  .div_valid_o (div_valid_o),
  .div_q       (ctl_q.div)
);

// File: tb/flash_tick_divider_tb_top.sv
`timescale 1ns/1ps
module flash_tick_divider_tb_top;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0;
  logic [7:0]        wdata = '0;
  logic [7:0]        rdata;
  logic              busy = 1'b0;
  logic              rseq = 1'b0;
  logic              tick;
  logic              valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model
  bit m_loaded;
  int m_div;
  int m_age;

  always #2 clk = ~clk;

  flash_tick_divider #(.ADDR_W(ADDR_W)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .addr_i      (addr),
    .wr_en_i     (wr_en),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .cmd_busy_i  (busy),
    .rst_seq_i   (rseq),
    .tick_o      (tick),
    .div_valid_o (valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_tick();
    return m_loaded && (((m_age + 1) % (m_div + 1)) == 0);
  endfunction

  function automatic int exp_rdata();
    if (addr != 0) return 0;
    return (m_loaded ? 128 : 0) + m_div;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_loaded <= 0; m_div <= 0; m_age <= 0;
    end else if (wr_en && addr == 0 && !m_loaded && (!busy || rseq)) begin
      m_loaded <= 1; m_div <= int'(wdata) % 128; m_age <= 0;
    end else if (m_loaded) begin
      m_age <= m_age + 1;
    end
  end

  // per-cycle comparison, sampled after the edge settles
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(rdata == 8'(exp_rdata()), "R2 rdata", int'(rdata), exp_rdata());
      chk(tick == exp_tick(), "R7 tick", int'(tick), int'(exp_tick()));
      chk(valid == m_loaded, "R9 valid", int'(valid), int'(m_loaded));
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d, input bit b, input bit s);
    @(negedge clk);
    addr = ADDR_W'(a); wdata = 8'(d); busy = b; rseq = s; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; busy = 1'b0; rseq = 1'b0; addr = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic count_ticks(input int n, input int exp, input string req);
    int cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (tick) cnt++;
    end
    chk(cnt == exp, req, cnt, exp);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(rdata == 8'h00, "R1 reset rdata", int'(rdata), 0);
    chk(valid == 1'b0, "R1 reset valid", int'(valid), 0);
    // R8 no tick before load
    count_ticks(20, 0, "R8 ticks while unloaded");

    // R5 busy write dropped
    wr(0, 8'h04, 1, 0);
    idle(1);
    chk(rdata == 8'h00, "R5 busy write dropped", int'(rdata), 0);
    // R10 other offset write ignored, R2 other offset reads 0
    wr(3, 8'h22, 0, 0);
    idle(1);
    chk(rdata == 8'h00, "R10 off-offset write", int'(rdata), 0);
    addr = 3;
    #1 chk(rdata == 8'h00, "R2 off-offset read", int'(rdata), 0);
    addr = 0;

    // R6 busy plus reset sequence accepted; R3 bit 7 of data
    wr(0, 8'h83, 1, 1);
    chk(rdata == 8'h83, "R6 seq write accepted", int'(rdata), 8'h83);
    // the tick window opens one cycle after the accepting edge (wr already spent 1)
    count_ticks(40, 10, "R7 tick count div=3");
    // R4 lockout
    wr(0, 8'h10, 0, 0);
    idle(1);
    chk(rdata == 8'h83, "R4 second write ignored", int'(rdata), 8'h83);

    // R3 flag set with bit 7 clear; R7 divisor 0
    do_reset();
    chk(rdata == 8'h00, "R1 reset after load", int'(rdata), 0);
    wr(0, 8'h00, 0, 0);
    chk(rdata == 8'h80, "R3 flag with div 0", int'(rdata), 8'h80);
    count_ticks(16, 16, "R7 div=0 every cycle");

    // R5 dropped write does not consume the one-time write
    do_reset();
    wr(0, 8'h7F, 1, 0);
    chk(valid == 1'b0, "R5 dropped no flag", int'(valid), 0);
    wr(0, 8'h05, 0, 0);
    chk(rdata == 8'h85, "R5 later write accepted", int'(rdata), 8'h85);
    count_ticks(60, 10, "R7 tick count div=5");

    // R7 maximum divisor
    do_reset();
    wr(0, 8'hFF, 0, 0);
    chk(rdata == 8'hFF, "R3 div 127 bit7 ignored", int'(rdata), 8'hFF);
    count_ticks(400, 3, "R7 tick count div=127");
    wr(0, 8'h01, 1, 1);
    idle(1);
    chk(rdata == 8'hFF, "R4 locked under seq write", int'(rdata), 8'hFF);

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule